// File: doc/BRIEF.md
# Timebase-Armed Periodic Pulse Generator

This block drives one output pin with a periodic waveform. The waveform is tied to a shared 64-bit nanosecond timebase that is counted elsewhere and arrives as an input bus. Software uses a single-cycle write port to program three things: an absolute 64-bit start time, split into two 32-bit words, a waveform mode, and a period length counted in reference-clock cycles. Once the timebase reaches the start time, the output produces its first edge. From then on it either inverts or emits a one-cycle pulse every `length` clock cycles.

A length of zero is the off state. The start-time words and the mode are only staged when they are written. They become active when a nonzero length is written. This allows software to take the generator down with a zero length, rewrite both start-time words and then start it again, and a half-written start time can never trigger an edge. Two frequency-trim words and a nudge word are held as plain storage. Several copies can share one timebase.

Top module: `pulse_gen_top`

## Requirements
- R1: After reset the output is low and the generator is off. It stays low for any timebase value until a nonzero length is written.
- R2: Writing length zero (word address 3) drives the output low from the next clock. The output then stays low for any timebase value.
- R3: The start-time words (word address 0 = bits 31:0, word address 1 = bits 63:32) and the mode (word address 2, bit 0) are staged only. Writing them while the generator runs leaves the output sequence unchanged.
- R4: After a nonzero length write, the output stays low while the timebase is below the active start time, compared as unsigned 64-bit values.
- R5: The first edge takes the output high on the clock that follows the first cycle in which timebase ≥ start time. This also holds when the timebase is already past the start time when the generator is armed.
- R6: In toggle mode (mode bit 0 = 0), the output inverts every `length` cycles after the first edge, so it is high for `length` cycles and low for `length` cycles.
- R7: In pulse mode (mode bit 0 = 1), the output is high for exactly one cycle every `length` cycles, starting at the first edge. A length of 1 holds it high continuously.
- R8: Writes to the trim words (word addresses 4 and 5), the nudge word (word address 6) and the unused word address 7 do not affect the output. Trim and nudge hold the last value written.
- R9: A nonzero length write while the generator runs restarts it. The output goes low on the next clock and the generator re-arms with the staged start time, mode and new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_ns | input | 64 | Shared nanosecond timebase |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| pulse_out | output | 1 | Generated waveform |

## Verification
A write takes effect on the clock edge that captures it. A length write therefore shows at the output one cycle later: the output is low from then on. Timebase is compared against the start time with no pipeline stage, so the first edge appears one clock after the timebase sample that meets the start time, and every later edge follows exactly `length` clocks after the previous one. The bench changes inputs only at falling edges and samples the pin at the following falling edge. It carries a cycle index that starts at the first edge and computes the expected level from that index, the length and the mode. Writes made during a run also advance that index, so a write that should be ignored is checked against the level due in that cycle.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;

    localparam int TB_W      = 64;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int CMP_WORDS = TB_W / REG_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CMP_LO  = 3'd0,
        ADDR_CMP_HI  = 3'd1,
        ADDR_CTRL    = 3'd2,
        ADDR_LEN     = 3'd3,
        ADDR_TRIM_LO = 3'd4,
        ADDR_TRIM_HI = 3'd5,
        ADDR_NUDGE   = 3'd6,
        ADDR_SPARE   = 3'd7
    } pg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } pg_state_e;

    typedef enum logic {
        WAVE_TOGGLE = 1'b0,
        WAVE_PULSE  = 1'b1
    } pg_wave_e;

    typedef struct packed {
        logic [TB_W-1:0]  cmp;
        logic [REG_W-1:0] len;
        pg_wave_e         mode;
    } pg_cfg_t;

    typedef struct packed {
        logic arm;
        logic disarm;
    } pg_cmd_t;

    function automatic logic [REG_W-1:0] reload_of(input logic [REG_W-1:0] len);
        return len - REG_W'(1);
    endfunction

    function automatic logic next_level(input pg_wave_e mode, input logic cur);
        return (mode == WAVE_TOGGLE) ? ~cur : 1'b1;
    endfunction

endpackage

// File: rtl/pulse_gen_regs.sv
module pulse_gen_regs
    import pulse_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output pg_cfg_t           staged,
    output pg_cmd_t           cmd,
    output logic [TB_W-1:0]   trim_q,
    output logic [REG_W-1:0]  nudge_q
);

    logic [REG_W-1:0] cmp_word [CMP_WORDS];
    logic             mode_q;
    logic             len_hit;

    // start-time words, one per slice of the timebase
    always_ff @(posedge clk) begin
        for (int w = 0; w < CMP_WORDS; w++) begin
            if (rst) begin
                cmp_word[w] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(w)) begin
                cmp_word[w] <= wr_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < CMP_WORDS; g++) begin : g_cmp_join
            assign staged.cmp[g*REG_W +: REG_W] = cmp_word[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            trim_q  <= '0;
            nudge_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:    mode_q                <= wr_data[0];
                ADDR_TRIM_LO: trim_q[REG_W-1:0]     <= wr_data;
                ADDR_TRIM_HI: trim_q[TB_W-1:REG_W]  <= wr_data;
                ADDR_NUDGE:   nudge_q               <= wr_data;
                default: ;
            endcase
        end
    end

    assign staged.mode = pg_wave_e'(mode_q);
    assign staged.len  = wr_data;

    assign len_hit    = wr_en && (wr_addr == ADDR_LEN);
    assign cmd.arm    = len_hit && (wr_data != '0);
    assign cmd.disarm = len_hit && (wr_data == '0);

endmodule

// File: rtl/pulse_gen_arm.sv
module pulse_gen_arm
    import pulse_gen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pg_cfg_t         staged,
    input  pg_cmd_t         cmd,
    input  logic [TB_W-1:0] tb_ns,
    output pg_cfg_t         act,
    output logic            armed,
    output logic            run,
    output logic            start,
    output logic            clear
);

    pg_state_e state_q;
    logic      reached;

    assign reached = (tb_ns >= act.cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            act     <= '0;
        end else if (cmd.arm) begin
            state_q <= ST_ARMED;
            act     <= staged;
        end else if (cmd.disarm) begin
            state_q <= ST_OFF;
            act.len <= '0;
        end else if (state_q == ST_ARMED && reached) begin
            state_q <= ST_RUN;
        end
    end

    assign armed = (state_q == ST_ARMED);
    assign run   = (state_q == ST_RUN);
    assign clear = cmd.arm || cmd.disarm;
    assign start = armed && reached && !clear;

endmodule

// File: rtl/pulse_gen_wave.sv
module pulse_gen_wave
    import pulse_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  logic             run,
    input  logic [REG_W-1:0] len,
    input  pg_wave_e         mode,
    output logic             wave
);

    logic [REG_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else if (start) begin
            cnt_q <= reload_of(len);
            wave  <= 1'b1;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_of(len);
                wave  <= next_level(mode, wave);
            end else begin
                cnt_q <= cnt_q - REG_W'(1);
                if (mode == WAVE_PULSE) begin
                    wave <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pulse_gen_top.sv
module pulse_gen_top
    import pulse_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TB_W-1:0]   tb_ns,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              pulse_out
);

    pg_cfg_t          staged;
    pg_cfg_t          act_cfg;
    pg_cmd_t          cmd;
    logic [TB_W-1:0]  trim_q;
    logic [REG_W-1:0] nudge_q;
    logic             armed;
    logic             run;
    logic             start;
    logic             clear;

    pulse_gen_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .staged  (staged),
        .cmd     (cmd),
        .trim_q  (trim_q),
        .nudge_q (nudge_q)
    );

    pulse_gen_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .staged (staged),
        .cmd    (cmd),
        .tb_ns  (tb_ns),
        .act    (act_cfg),
        .armed  (armed),
        .run    (run),
        .start  (start),
        .clear  (clear)
    );

    pulse_gen_wave u_wave (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .start (start),
        .run   (run),
        .len   (act_cfg.len),
        .mode  (act_cfg.mode),
        .wave  (pulse_out)
    );

endmodule

// File: rtl/pulse_gen_checker.sv
module pulse_gen_checker
    import pulse_gen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TB_W-1:0]   tb_ns,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              pulse_out,
    input logic [TB_W-1:0]   act_cmp,
    input logic [REG_W-1:0]  act_len,
    input pg_wave_e          act_mode,
    input logic              armed,
    input logic              run,
    input logic [TB_W-1:0]   trim_q,
    input logic [REG_W-1:0]  nudge_q
);

    logic len_wr;
    assign len_wr = wr_en && (wr_addr == ADDR_LEN);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (len_wr && wr_data == '0) |=> !pulse_out); // R2

    AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (armed && tb_ns < act_cmp) |=> !pulse_out); // R4

    AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (rst)
        (armed && tb_ns >= act_cmp && !len_wr) |=> pulse_out); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (run && act_mode == WAVE_PULSE && act_len > 1 && pulse_out && !len_wr)
        |=> !pulse_out); // R7

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en && (wr_addr == ADDR_CMP_LO || wr_addr == ADDR_CMP_HI || wr_addr == ADDR_CTRL))
        |=> ($stable(act_cmp) && $stable(act_mode))); // R3

    AST_TRIM_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_TRIM_LO) |=> (trim_q[REG_W-1:0] == $past(wr_data))); // R8

    AST_NUDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_NUDGE) |=> (nudge_q == $past(wr_data))); // R8

    AST_TRIM_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_TRIM_HI) |=> (trim_q[TB_W-1:REG_W] == $past(wr_data))); // R8

endmodule

bind pulse_gen_top pulse_gen_checker u_pulse_gen_checker (
    .clk       (clk),
    .rst       (rst),
    .tb_ns     (tb_ns),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_out (pulse_out),
    .act_cmp   (act_cfg.cmp),
    .act_len   (act_cfg.len),
    .act_mode  (act_cfg.mode),
    .armed     (armed),
    .run       (run),
    .trim_q    (trim_q),
    .nudge_q   (nudge_q)
);

// File: tb/pulse_gen_top_bench.sv
module pulse_gen_top_bench;
    import pulse_gen_pkg::*;

    localparam int NVEC = 5;
    localparam logic [63:0] V_CMP [NVEC] = '{
        64'h0000_0001_0000_0100,
        64'h0000_0000_0000_0100,
        64'h0000_0000_8000_0000,
        64'h0000_0002_0000_0000,
        64'hFFFF_FFFF_0000_0010
    };
    localparam int V_LEN [NVEC] = '{3, 1, 4, 1, 5};
    localparam bit V_PULSE [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tb_ns = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pulse_out;

    int tests = 0;
    int fails = 0;
    int k = 0;
    int cur_len = 1;
    bit cur_pulse = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_gen_top u_pulse_gen_top (
        .clk       (clk),
        .rst       (rst),
        .tb_ns     (tb_ns),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    function automatic logic exp_level(int idx, int len, bit pulse);
        if (pulse) return (idx % len) == 0;
        return ((idx / len) % 2) == 0;
    endfunction

    task automatic check(logic got, logic want, string req);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: pulse_out=%0b expected %0b (time %0t)", req, got, want, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic tick_chk(string req);
        tick();
        k++;
        check(pulse_out, exp_level(k, cur_len, cur_pulse), req);
    endtask

    task automatic wr_chk(logic [2:0] a, logic [31:0] d, string req);
        wr(a, d);
        k++;
        check(pulse_out, exp_level(k, cur_len, cur_pulse), req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pulse_out, 1'b0, "R1 reset level");
        tb_ns = '1;
        repeat (3) begin
            tick();
            check(pulse_out, 1'b0, "R1 off before length");
        end

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(ADDR_LEN, 32'd0);
            check(pulse_out, 1'b0, "R2 zero length");
            wr(ADDR_CMP_HI, V_CMP[i][63:32]);
            wr(ADDR_CMP_LO, V_CMP[i][31:0]);
            wr(ADDR_CTRL, {31'd0, V_PULSE[i]});
            tb_ns = V_CMP[i] - 64'd1;
            wr(ADDR_LEN, 32'(V_LEN[i]));
            check(pulse_out, 1'b0, "R4 armed below start");
            repeat (2) begin
                tick();
                check(pulse_out, 1'b0, "R4 armed below start");
            end
            tb_ns = V_CMP[i];
            tick();
            check(pulse_out, 1'b1, "R5 first edge at start");
            k = 0;
            cur_len = V_LEN[i];
            cur_pulse = V_PULSE[i];
            for (int j = 1; j <= 3 * V_LEN[i] + 1; j++) begin
                tick_chk(V_PULSE[i] ? "R7 pulse cadence" : "R6 toggle cadence");
            end
        end

        // armed while the timebase is already past the start time
        wr(ADDR_LEN, 32'd0);
        wr(ADDR_CMP_HI, 32'd0);
        wr(ADDR_CMP_LO, 32'h1000);
        wr(ADDR_CTRL, 32'd0);
        tb_ns = 64'h2000;
        wr(ADDR_LEN, 32'd4);
        check(pulse_out, 1'b0, "R5 armed late, not yet");
        tick();
        check(pulse_out, 1'b1, "R5 armed late, edge");
        k = 0;
        cur_len = 4;
        cur_pulse = 1'b0;

        wr_chk(ADDR_TRIM_LO, 32'hDEAD_BEEF, "R8 trim low ignored");
        wr_chk(ADDR_TRIM_HI, 32'h0000_0001, "R8 trim high ignored");
        wr_chk(ADDR_NUDGE, 32'h0000_00FF, "R8 nudge ignored");
        wr_chk(ADDR_SPARE, 32'hFFFF_FFFF, "R8 spare address ignored");
        wr_chk(ADDR_CMP_HI, 32'd2, "R3 staged high word");
        wr_chk(ADDR_CMP_LO, 32'd0, "R3 staged low word");
        wr_chk(ADDR_CTRL, 32'd1, "R3 staged mode");
        repeat (3) tick_chk("R3 run unchanged");

        // restart with staged values
        wr(ADDR_LEN, 32'd6);
        check(pulse_out, 1'b0, "R9 restart low");
        repeat (3) begin
            tick();
            check(pulse_out, 1'b0, "R9 re-armed waits");
        end
        tb_ns = 64'h0000_0002_0000_0000;
        tick();
        check(pulse_out, 1'b1, "R9 restart edge");
        k = 0;
        cur_len = 6;
        cur_pulse = 1'b1;
        repeat (7) tick_chk("R7 pulse after restart");

        wr(ADDR_LEN, 32'd0);
        check(pulse_out, 1'b0, "R2 disable while running");
        tb_ns = '1;
        repeat (4) begin
            tick();
            check(pulse_out, 1'b0, "R2 stays low");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule